// File: doc/BRIEF.md
# Synchronous Memory Decoder with Mapped Output Register

This block is the storage side of a small processor. It takes one address, one write-data byte and one write enable per clock. It splits the address space into three regions:

- The lower half is a read/write RAM.
- The topmost address is a single writable register. That register drives an output port.
- Every remaining upper-half address is unmapped.

Every access has exactly one cycle of read latency, whatever region it hits. The address is sampled on a rising edge, and the matching read data is on the read port before the next rising edge.

The block meets that latency with a registered selection state. On every edge the decoder records which region the sampled address fell in. The RAM read register and the output register update on that same edge. A read-data multiplexer then follows the recorded selection. Because of this, back-to-back accesses to different regions each return their own component's data.

Top module: `memdec_top`

## Requirements
- R1: The read data for an address sampled at a rising edge is present on `rdata_o` after that edge and before the following one, for every region.
- R2: Addresses 0x00 to 0x7F reach a 128-location RAM: a write stores `wdata_i` at that location, and a later read of it returns the stored byte.
- R3: Address 0xFF is a register. A write loads `wdata_i` into it, its value always drives `reg_out_o`, and a read of 0xFF returns its current contents.
- R4: A read of any address from 0x80 to 0xFE returns 0x00.
- R5: A write to any address from 0x80 to 0xFE has no effect. No RAM location changes, including the location equal to the low seven address bits, and `reg_out_o` holds.
- R6: A write is read-first-free. In the write cycle, `rdata_o` returns the byte just written (for the RAM and the register alike), and a read of the same location at the next edge returns the new value.
- R7: While reset (`rst_i` high, sampled synchronously) is applied, and until the first address is sampled after it, `rdata_o` and `reg_out_o` are 0x00.
- R8: Consecutive accesses that alternate among RAM, register and unmapped addresses each return the data of the region their own address selected, never the previous access's region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 8 | Access address, sampled each rising edge |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write enable for the sampled address |
| rdata_o | output | 8 | Read data for the address sampled at the last edge |
| reg_out_o | output | 8 | Contents of the register at 0xFF |

## Verification
The test begins with a full RAM fill, with a distinct byte pattern at each location, followed by a full read-back; this shows that each location is separately addressable. Walks through unmapped addresses, with reads and with writes, separate true unmapped behaviour from aliasing onto the low seven address bits or onto the register. Writes followed at once by reads of the same location check the write-cycle data and the one-cycle visibility of the new value. Sequences that alternate between regions on every cycle expose any stale or mis-timed read-data selection.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

   // Region picked by the address decoder; held one cycle to steer read data
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_RAM  = 2'd1,
      SEL_REG  = 2'd2
   } sel_e;

endpackage

// File: rtl/memdec_decode.sv
module memdec_decode
   import memdec_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned RAM_AW   = 7,
   parameter int unsigned REG_ADDR = 255
) (
   input  logic [ADDR_W-1:0] addr_i,
   output sel_e              sel_o
);

   localparam int unsigned HI_W = ADDR_W - RAM_AW;
   localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);

   // Elaboration-time parameter checks
   generate
      if (RAM_AW >= ADDR_W) begin : g_bad_ram_aw
         $error("memdec_decode: RAM_AW must be smaller than ADDR_W");
      end
      if (REG_ADDR < (2 ** RAM_AW) || REG_ADDR >= (2 ** ADDR_W)) begin : g_bad_reg_addr
         $error("memdec_decode: REG_ADDR must lie in the upper part of the space");
      end
   endgenerate

   logic [HI_W-1:0] hi_bits;
   assign hi_bits = addr_i[ADDR_W-1:RAM_AW];

   always_comb begin
      if (hi_bits == '0) begin
         sel_o = SEL_RAM;
      end else if (addr_i == REG_A) begin
         sel_o = SEL_REG;
      end else begin
         sel_o = SEL_NONE;
      end
   end

endmodule

// File: rtl/memdec_ram.sv
module memdec_ram #(
   parameter int unsigned AW = 7,
   parameter int unsigned DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          en_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] rdata_o
);

   localparam int unsigned DEPTH = 2 ** AW;

   generate
      if (DW == 0) begin : g_bad_dw
         $error("memdec_ram: DW must be non-zero");
      end
   endgenerate

   logic [DW-1:0] mem_q [DEPTH];
   logic [DW-1:0] rd_q;

   always_ff @(posedge clk_i) begin
      if (en_i && we_i) begin
         mem_q[addr_i] <= wdata_i;
      end
   end

   // Write cycle returns the new byte; otherwise the stored one
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rd_q <= '0;
      end else if (en_i) begin
         rd_q <= we_i ? wdata_i : mem_q[addr_i];
      end
   end

   assign rdata_o = rd_q;

   AST_RAM_WRITE_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && we_i) |=> (rdata_o == $past(wdata_i))); // R6

   AST_RAM_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (!en_i) |=> $stable(rdata_o)); // R8

endmodule

// File: rtl/memdec_out_reg.sv
module memdec_out_reg #(
   parameter int unsigned DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          load_i,
   input  logic [DW-1:0] d_i,
   output logic [DW-1:0] q_o
);

   logic [DW-1:0] q_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         q_q <= '0;
      end else if (load_i) begin
         q_q <= d_i;
      end
   end

   assign q_o = q_q;

   AST_REG_RESET_VALUE: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(rst_i) |-> (q_o == '0)); // R7

   AST_REG_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
      load_i |=> (q_o == $past(d_i))); // R3

   AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i) |=> $stable(q_o)); // R5

endmodule

// File: rtl/memdec_rd_steer.sv
module memdec_rd_steer
   import memdec_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  sel_e          sel_i,
   input  logic [DW-1:0] ram_rd_i,
   input  logic [DW-1:0] reg_q_i,
   output logic [DW-1:0] rdata_o
);

   sel_e sel_q;

   // Remember which region the address sampled at this edge selected
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sel_q <= SEL_NONE;
      end else begin
         sel_q <= sel_i;
      end
   end

   always_comb begin
      unique case (sel_q)
         SEL_RAM: rdata_o = ram_rd_i;
         SEL_REG: rdata_o = reg_q_i;
         default: rdata_o = '0;
      endcase
   end

   AST_STEER_NONE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_i == SEL_NONE) |=> (rdata_o == '0)); // R4

   AST_STEER_RAM_PATH: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_i == SEL_RAM) |=> (rdata_o == ram_rd_i)); // R8

   AST_STEER_REG_PATH: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_i == SEL_REG) |=> (rdata_o == reg_q_i)); // R1

endmodule

// File: rtl/memdec_top.sv
module memdec_top
   import memdec_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned RAM_AW   = 7,
   parameter int unsigned REG_ADDR = 255
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              we_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] reg_out_o
);

   localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);

   sel_e              sel_now;
   logic              ram_en;
   logic              reg_load;
   logic [DATA_W-1:0] ram_rd;
   logic [DATA_W-1:0] reg_q;

   memdec_decode #(
      .ADDR_W   (ADDR_W),
      .RAM_AW   (RAM_AW),
      .REG_ADDR (REG_ADDR)
   ) u_decode (
      .addr_i (addr_i),
      .sel_o  (sel_now)
   );

   assign ram_en   = (sel_now == SEL_RAM);
   assign reg_load = (sel_now == SEL_REG) && we_i;

   memdec_ram #(
      .AW (RAM_AW),
      .DW (DATA_W)
   ) u_ram (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (ram_en),
      .we_i    (we_i),
      .addr_i  (addr_i[RAM_AW-1:0]),
      .wdata_i (wdata_i),
      .rdata_o (ram_rd)
   );

   memdec_out_reg #(
      .DW (DATA_W)
   ) u_out_reg (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (reg_load),
      .d_i    (wdata_i),
      .q_o    (reg_q)
   );

   memdec_rd_steer #(
      .DW (DATA_W)
   ) u_steer (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .sel_i    (sel_now),
      .ram_rd_i (ram_rd),
      .reg_q_i  (reg_q),
      .rdata_o  (rdata_o)
   );

   assign reg_out_o = reg_q;

   AST_REG_READBACK: assert property (@(posedge clk_i) disable iff (rst_i)
      (addr_i == REG_A) |=> (rdata_o == reg_out_o)); // R3

   AST_REG_WRITE_ECHO: assert property (@(posedge clk_i) disable iff (rst_i)
      (addr_i == REG_A && we_i) |=> (rdata_o == $past(wdata_i))); // R6

   AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
      (addr_i[ADDR_W-1:RAM_AW] != '0 && addr_i != REG_A) |=> $stable(reg_out_o)); // R5

   AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (addr_i[ADDR_W-1:RAM_AW] != '0 && addr_i != REG_A) |=> (rdata_o == '0)); // R4

endmodule

// File: tb/memdec_top_tb.sv
module memdec_top_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk;
   logic       rst;
   logic [7:0] addr;
   logic [7:0] wdata;
   logic       we;
   logic [7:0] rdata;
   logic [7:0] reg_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Behavioural reference model
   logic [7:0] ref_ram [128];
   logic [7:0] ref_reg;
   logic [7:0] ref_rd;

   memdec_top u_dut (
      .clk_i     (clk),
      .rst_i     (rst),
      .addr_i    (addr),
      .wdata_i   (wdata),
      .we_i      (we),
      .rdata_o   (rdata),
      .reg_out_o (reg_out)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check8(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   // Model update for one sampled access (rules from R2..R6)
   task automatic model_step(input logic [7:0] a, input logic w, input logic [7:0] d);
      if (a < 8'h80) begin
         if (w) ref_ram[a[6:0]] = d;
         ref_rd = ref_ram[a[6:0]];
      end else if (a == 8'hFF) begin
         if (w) ref_reg = d;
         ref_rd = ref_reg;
      end else begin
         ref_rd = 8'h00;
      end
   endtask

   // Drive at falling edge, model at rising edge, compare at the next falling edge
   task automatic access(input logic [7:0] a, input logic w, input logic [7:0] d,
                         input string tag);
      addr  = a;
      we    = w;
      wdata = d;
      @(posedge clk);
      model_step(a, w, d);
      @(negedge clk);
      check8(tag, "rdata", rdata, ref_rd);
      check8(tag, "reg_out", reg_out, ref_reg);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      rst   = 1'b1;
      addr  = 8'h00;
      wdata = 8'h00;
      we    = 1'b0;
      ref_reg = 8'h00;
      ref_rd  = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check8("R7", "rdata in reset", rdata, 8'h00);
      check8("R7", "reg_out in reset", reg_out, 8'h00);
      rst = 1'b0;
      check8("R7", "rdata after release", rdata, 8'h00);

      // R2 fill with distinct patterns, then read back
      for (int i = 0; i < 128; i++) access(8'(i), 1'b1, 8'((i * 37 + 5) & 8'hFF), "R2");
      for (int i = 0; i < 128; i++) access(8'(i), 1'b0, 8'h00, "R2");

      // R4 unmapped reads
      access(8'h80, 1'b0, 8'h00, "R4");
      access(8'h81, 1'b0, 8'h00, "R4");
      access(8'hC3, 1'b0, 8'h00, "R4");
      access(8'hFE, 1'b0, 8'h00, "R4");

      // R3 register write, read back
      access(8'hFF, 1'b1, 8'hA5, "R3");
      access(8'hFF, 1'b0, 8'h00, "R3");
      access(8'h00, 1'b0, 8'h00, "R3");

      // R5 unmapped writes: no alias onto low bits, register holds
      access(8'h85, 1'b1, 8'h11, "R5");
      access(8'hFE, 1'b1, 8'h22, "R5");
      access(8'hC0, 1'b1, 8'h33, "R5");
      access(8'h05, 1'b0, 8'h00, "R5");
      access(8'h7E, 1'b0, 8'h00, "R5");
      access(8'h40, 1'b0, 8'h00, "R5");

      // R6 write cycle echoes data; next read sees new value
      access(8'h10, 1'b1, 8'h5A, "R6");
      access(8'h10, 1'b0, 8'h00, "R6");
      access(8'hFF, 1'b1, 8'h3C, "R6");
      access(8'hFF, 1'b0, 8'h00, "R6");
      access(8'h7F, 1'b1, 8'hE1, "R6");
      access(8'h7F, 1'b1, 8'hE2, "R6");
      access(8'h7F, 1'b0, 8'h00, "R6");

      // R8 alternate regions every cycle
      access(8'h10, 1'b0, 8'h00, "R8");
      access(8'hFF, 1'b0, 8'h00, "R8");
      access(8'h90, 1'b0, 8'h00, "R8");
      access(8'h11, 1'b0, 8'h00, "R8");
      access(8'hFF, 1'b0, 8'h00, "R8");
      access(8'h7F, 1'b0, 8'h00, "R8");
      access(8'hFE, 1'b0, 8'h00, "R8");
      access(8'hFF, 1'b1, 8'h00, "R8");
      access(8'h03, 1'b0, 8'h00, "R8");

      // R1 back-to-back distinct reads, one per cycle
      for (int i = 0; i < 16; i++) access(8'(i * 8), 1'b0, 8'h00, "R1");
      access(8'hFF, 1'b1, 8'h96, "R1");
      access(8'h20, 1'b0, 8'h00, "R1");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule